// File: doc/BRIEF.md
# Multichannel Time-Shared Biquad Decimation Filter

This block recovers baseband values from several two-level duty-cycle-modulated bitstreams. On each sample strobe every channel supplies one bit. A single second-order low-pass IIR datapath serves all channels in turn. Each channel keeps its own delay-line history, which is read and written back only in that channel's slot. The denominator's poles sit a fraction of a thousandth inside z = 1, so the coefficients and the recursive state carry 44 fractional bits.

A two-state controller runs the engine. `ST_IDLE` waits for a strobe; the transition *accept* captures all channel bits and enters `ST_RUN`. `ST_RUN` processes channels 0 to N_CH-1, one per clock. From the last slot there are two transitions. *chain* is taken when a strobe is present: it captures a new sample and stays in `ST_RUN`. *retire* is taken when no strobe is present and returns to `ST_IDLE`. A strobe in any other `ST_RUN` slot is dropped. Each result is quantized to a signed word and saturated. It then leaves on a shared result port, carrying the channel index and a one-cycle valid. It is also routed to that channel's own holding register.

The clock must be at least N_CH times the sample rate. The output scale can be raised by a power of two (`OUT_GAIN_SHL`, default 0, which gives unity DC gain, so a constant input settles at full scale).

Top module: `mcbq_filter`

## Requirements
- R1: A synchronous reset clears the controller to `ST_IDLE`, all per-channel history, `res_vld`, `res_ch`, `res_word` and every holding register in `ch_words` to zero.
- R2: A strobe sampled in `ST_IDLE` captures all of `ds_bits` at that clock edge. `res_vld` stays low in the following cycle and rises one cycle later with `res_ch` = 0.
- R3: After an accepted strobe, `res_vld` is high for N_CH consecutive cycles, with `res_ch` taking the values 0, 1, ..., N_CH-1 in that order.
- R4: A strobe sampled in the cycle in which the last channel is computed starts the next pass at once, so `res_vld` has no gap between the two passes and the second pass again starts at channel 0.
- R5: A strobe sampled while the engine is busy with any channel other than the last is ignored: no extra result appears, the running pass is not restarted, and the bits offered with it never reach any channel's history.
- R6: A bit value of 1 enters the filter as +1 and 0 as -1. After reset, the past-input and past-output history of every channel reads as zero, not as -1.
- R7: With taps at scale 2^-44, the filter computes y = 1453738·x0 + 2907476·x1 + 1453738·x2 + 35180464440230·y1 - 17588284210766·y2. Here x0 is the newest input and y1, y2 are earlier outputs. The exact sum is rounded half up to 44 fractional bits before it is stored as the channel's next y1. These integers make the numerator sum equal to the denominator value at z = 1.
- R8: The output word is floor(y·2^(15+OUT_GAIN_SHL) + 1/2), in 16-bit two's complement.
- R9: A word that would exceed 32767 is output as 32767, and one below -32768 as -32768. The stored state keeps its unsaturated value.
- R10: Each channel's history changes only in its own slot, so channels fed different bit patterns evolve independently.
- R11: The 16-bit field c of `ch_words` (bits 16c+15 down to 16c) holds the last word produced for channel c and keeps it until that channel's next result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | Sample strobe: one new bit per channel |
| ds_bits | input | N_CH | Current bitstream bit of each channel (bit c is channel c) |
| res_vld | output | 1 | One-cycle valid for the shared result port |
| res_ch | output | CH_W | Channel index of the current result |
| res_word | output | OUT_W | Quantized, saturated filter output |
| ch_words | output | N_CH*OUT_W | Per-channel holding registers, channel c in field c |

## Verification
The two things that can fall in one cycle are computing the last channel of a pass and accepting the strobe for the next pass. A long stream places every strobe exactly in that last-slot cycle. The bench expects `res_vld` to stay high across pass boundaries, and every word to match a reference recurrence that has absorbed all the chained samples. A second case puts a strobe in a mid-pass slot with bits different from the real stream. The bench then expects neither an extra result nor any trace of those bits in later outputs, which a reference that never saw them would reveal. Constant-high and constant-low channels run long enough to saturate in both directions, while the other channels carry a 60% duty square wave and a pseudo-random pattern.

// File: rtl/mcbq_pkg.sv
package mcbq_pkg;

    // Fixed-point layout of coefficients and recursive state
    localparam int COEF_FRAC = 44;
    localparam int COEF_W    = 47;
    localparam int STATE_W   = 48;

    // Numerator taps: outer taps on x0 and x2, middle tap on x1
    localparam logic signed [COEF_W-1:0] K_B_OUTER = 47'sd1453738;
    localparam logic signed [COEF_W-1:0] K_B_MID   = 47'sd2907476;
    // Denominator: y depends on -K_A1*y1 - K_A2*y2
    localparam logic signed [COEF_W-1:0] K_A1      = -47'sd35180464440230;
    localparam logic signed [COEF_W-1:0] K_A2      = 47'sd17588284210766;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    // One past input: on=0 means no sample yet (value zero)
    typedef struct packed {
        logic on;
        logic pos;
    } xtap_t;

endpackage

// File: rtl/mcbq_seq.sv
module mcbq_seq
    import mcbq_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            smp_stb,
    input  logic [N_CH-1:0] ds_bits,
    output logic            busy,
    output logic [CH_W-1:0] cur_ch,
    output logic            cur_bit
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_CH - 1);

    seq_state_t      state_q;
    seq_state_t      state_d;
    logic [N_CH-1:0] bits_q;
    logic            last_slot;
    logic            accept;

    assign last_slot = (cur_ch == LAST_CH);

    // Next-state and capture decision
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (smp_stb) begin
                    accept  = 1'b1;
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (last_slot) begin
                    if (smp_stb) begin
                        accept = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Slot counter and captured bits
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_ch <= '0;
            bits_q <= '0;
        end else if (accept) begin
            cur_ch <= '0;
            bits_q <= ds_bits;
        end else if (state_q == ST_RUN) begin
            cur_ch <= last_slot ? '0 : cur_ch + 1'b1;
        end
    end

    assign busy    = (state_q == ST_RUN);
    assign cur_bit = bits_q[cur_ch];

endmodule

// File: rtl/mcbq_hist.sv
module mcbq_hist
    import mcbq_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int CH_W = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [CH_W-1:0]           wr_ch,
    input  logic                      new_bit,
    input  logic signed [STATE_W-1:0] y_new,
    output xtap_t                     rd_x1,
    output xtap_t                     rd_x2,
    output logic signed [STATE_W-1:0] rd_y1,
    output logic signed [STATE_W-1:0] rd_y2
);

    xtap_t                     x1_all [N_CH];
    xtap_t                     x2_all [N_CH];
    logic signed [STATE_W-1:0] y1_all [N_CH];
    logic signed [STATE_W-1:0] y2_all [N_CH];

    for (genvar g = 0; g < N_CH; g++) begin : gen_slot
        xtap_t                     x1_q;
        xtap_t                     x2_q;
        logic signed [STATE_W-1:0] y1_q;
        logic signed [STATE_W-1:0] y2_q;
        logic                      mine;

        assign mine = wr_en && (wr_ch == CH_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                x1_q <= '0;
                x2_q <= '0;
                y1_q <= '0;
                y2_q <= '0;
            end else if (mine) begin
                x2_q    <= x1_q;
                x1_q.on <= 1'b1;
                x1_q.pos <= new_bit;
                y2_q    <= y1_q;
                y1_q    <= y_new;
            end
        end

        assign x1_all[g] = x1_q;
        assign x2_all[g] = x2_q;
        assign y1_all[g] = y1_q;
        assign y2_all[g] = y2_q;
    end

    assign rd_x1 = x1_all[wr_ch];
    assign rd_x2 = x2_all[wr_ch];
    assign rd_y1 = y1_all[wr_ch];
    assign rd_y2 = y2_all[wr_ch];

endmodule

// File: rtl/mcbq_mac.sv
module mcbq_mac
    import mcbq_pkg::*;
(
    input  logic                      x_now,
    input  xtap_t                     x1,
    input  xtap_t                     x2,
    input  logic signed [STATE_W-1:0] y1,
    input  logic signed [STATE_W-1:0] y2,
    output logic signed [STATE_W-1:0] y_new
);

    localparam int TAP_W  = COEF_W + 2;
    localparam int PROD_W = STATE_W + COEF_W;
    localparam int ACC_W  = PROD_W + 3;
    localparam logic signed [ACC_W-1:0] HALF_LSB =
        {{(ACC_W-1){1'b0}}, 1'b1} << (COEF_FRAC - 1);

    // +1/-1/0 times a coefficient is a select and negate
    function automatic logic signed [TAP_W-1:0] tap_term(
        input logic on, input logic pos, input logic signed [COEF_W-1:0] k);
        logic signed [TAP_W-1:0] kx;
        kx = TAP_W'(k);
        if (!on) begin
            return '0;
        end
        return pos ? kx : -kx;
    endfunction

    logic signed [TAP_W-1:0]  ff_sum;
    logic signed [ACC_W-1:0]  ff_ext;
    logic signed [PROD_W-1:0] fb1;
    logic signed [PROD_W-1:0] fb2;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  acc_rnd;

    always_comb begin
        ff_sum  = tap_term(1'b1, x_now, K_B_OUTER)
                + tap_term(x1.on, x1.pos, K_B_MID)
                + tap_term(x2.on, x2.pos, K_B_OUTER);
        ff_ext  = ACC_W'(ff_sum) <<< COEF_FRAC;
        fb1     = K_A1 * y1;
        fb2     = K_A2 * y2;
        acc     = ff_ext - ACC_W'(fb1) - ACC_W'(fb2);
        acc_rnd = acc + HALF_LSB;
        y_new   = acc_rnd[COEF_FRAC +: STATE_W];
    end

endmodule

// File: rtl/mcbq_outq.sv
module mcbq_outq
    import mcbq_pkg::*;
#(
    parameter int N_CH         = 4,
    parameter int CH_W         = 2,
    parameter int OUT_W        = 16,
    parameter int OUT_GAIN_SHL = 0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      calc_en,
    input  logic [CH_W-1:0]           calc_ch,
    input  logic signed [STATE_W-1:0] y_in,
    output logic                      res_vld,
    output logic [CH_W-1:0]           res_ch,
    output logic [OUT_W-1:0]          res_word,
    output logic [N_CH*OUT_W-1:0]     ch_words
);

    localparam int QW        = STATE_W + 1;
    localparam int OUT_SHIFT = COEF_FRAC - (OUT_W - 1) - OUT_GAIN_SHL;
    localparam int HI_W      = QW - OUT_W + 1;
    localparam logic signed [QW-1:0] HALF_Q =
        {{(QW-1){1'b0}}, 1'b1} << (OUT_SHIFT - 1);
    localparam logic [OUT_W-1:0] POS_FULL = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_FULL = {1'b1, {(OUT_W-1){1'b0}}};

    logic signed [QW-1:0] q_sum;
    logic signed [QW-1:0] q_val;
    logic [HI_W-1:0]      q_hi;
    logic [OUT_W-1:0]     word;

    always_comb begin
        q_sum = QW'(y_in) + HALF_Q;
        q_val = q_sum >>> OUT_SHIFT;
        q_hi  = q_val[QW-1:OUT_W-1];
        if ((q_hi == '0) || (q_hi == '1)) begin
            word = q_val[OUT_W-1:0];
        end else if (q_val[QW-1]) begin
            word = NEG_FULL;
        end else begin
            word = POS_FULL;
        end
    end

    // Shared result port
    always_ff @(posedge clk) begin
        if (rst) begin
            res_vld  <= 1'b0;
            res_ch   <= '0;
            res_word <= '0;
        end else begin
            res_vld <= calc_en;
            if (calc_en) begin
                res_ch   <= calc_ch;
                res_word <= word;
            end
        end
    end

    // Output demultiplexer into per-channel holding registers
    for (genvar g = 0; g < N_CH; g++) begin : gen_hold
        logic [OUT_W-1:0] hold_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q <= '0;
            end else if (calc_en && (calc_ch == CH_W'(g))) begin
                hold_q <= word;
            end
        end
        assign ch_words[g*OUT_W +: OUT_W] = hold_q;
    end

endmodule

// File: rtl/mcbq_filter.sv
module mcbq_filter
    import mcbq_pkg::*;
#(
    parameter int N_CH         = 4,
    parameter int OUT_W        = 16,
    parameter int OUT_GAIN_SHL = 0,
    parameter int CH_W         = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  smp_stb,
    input  logic [N_CH-1:0]       ds_bits,
    output logic                  res_vld,
    output logic [CH_W-1:0]       res_ch,
    output logic [OUT_W-1:0]      res_word,
    output logic [N_CH*OUT_W-1:0] ch_words
);

    logic                      busy;
    logic [CH_W-1:0]           cur_ch;
    logic                      cur_bit;
    xtap_t                     rd_x1;
    xtap_t                     rd_x2;
    logic signed [STATE_W-1:0] rd_y1;
    logic signed [STATE_W-1:0] rd_y2;
    logic signed [STATE_W-1:0] y_new;

    mcbq_seq #(.N_CH(N_CH), .CH_W(CH_W)) i_seq (
        .clk     (clk),
        .rst     (rst),
        .smp_stb (smp_stb),
        .ds_bits (ds_bits),
        .busy    (busy),
        .cur_ch  (cur_ch),
        .cur_bit (cur_bit)
    );

    mcbq_hist #(.N_CH(N_CH), .CH_W(CH_W)) i_hist (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (busy),
        .wr_ch   (cur_ch),
        .new_bit (cur_bit),
        .y_new   (y_new),
        .rd_x1   (rd_x1),
        .rd_x2   (rd_x2),
        .rd_y1   (rd_y1),
        .rd_y2   (rd_y2)
    );

    mcbq_mac i_mac (
        .x_now (cur_bit),
        .x1    (rd_x1),
        .x2    (rd_x2),
        .y1    (rd_y1),
        .y2    (rd_y2),
        .y_new (y_new)
    );

    mcbq_outq #(
        .N_CH         (N_CH),
        .CH_W         (CH_W),
        .OUT_W        (OUT_W),
        .OUT_GAIN_SHL (OUT_GAIN_SHL)
    ) i_outq (
        .clk      (clk),
        .rst      (rst),
        .calc_en  (busy),
        .calc_ch  (cur_ch),
        .y_in     (y_new),
        .res_vld  (res_vld),
        .res_ch   (res_ch),
        .res_word (res_word),
        .ch_words (ch_words)
    );

endmodule

// File: rtl/mcbq_filter_chk.sv
module mcbq_filter_chk #(
    parameter int N_CH  = 4,
    parameter int OUT_W = 16,
    parameter int CH_W  = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  smp_stb,
    input logic                  busy,
    input logic [CH_W-1:0]       cur_ch,
    input logic                  res_vld,
    input logic [CH_W-1:0]       res_ch,
    input logic [OUT_W-1:0]      res_word,
    input logic [N_CH*OUT_W-1:0] ch_words
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_CH - 1);

    logic             prev_vld;
    logic [CH_W-1:0]  prev_ch;
    logic [OUT_W-1:0] prev_word;
    logic [OUT_W-1:0] sel_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_vld  <= 1'b0;
            prev_ch   <= '0;
            prev_word <= '0;
        end else begin
            prev_vld  <= res_vld;
            prev_ch   <= res_ch;
            prev_word <= res_word;
        end
    end

    assign sel_word = ch_words[int'(prev_ch)*OUT_W +: OUT_W];

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_vld && res_word == '0 && ch_words == '0)); // R1

    AST_IDLE_START: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && !busy) |=> ##1 (res_vld && res_ch == '0)); // R2

    AST_CH_STEP: assert property (@(posedge clk) disable iff (rst)
        (res_vld && res_ch != LAST_CH) |=>
            (res_vld && res_ch == CH_W'($past(res_ch) + 1'b1))); // R3

    AST_PASS_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(res_vld) |-> (res_ch == '0)); // R3

    AST_CHAIN_NO_GAP: assert property (@(posedge clk) disable iff (rst)
        (busy && cur_ch == LAST_CH && smp_stb) |=> ##1 (res_vld && res_ch == '0)); // R4

    AST_BUSY_STB_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (busy && cur_ch != LAST_CH && smp_stb) |=>
            (busy && cur_ch == CH_W'($past(cur_ch) + 1'b1))); // R5

    AST_HOLD_MATCHES: assert property (@(posedge clk) disable iff (rst)
        prev_vld |-> (sel_word == prev_word)); // R11

endmodule

bind mcbq_filter mcbq_filter_chk #(
    .N_CH  (N_CH),
    .OUT_W (OUT_W),
    .CH_W  (CH_W)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_stb  (smp_stb),
    .busy     (busy),
    .cur_ch   (cur_ch),
    .res_vld  (res_vld),
    .res_ch   (res_ch),
    .res_word (res_word),
    .ch_words (ch_words)
);

// File: tb/test_mcbq_filter.sv
module test_mcbq_filter;

    localparam int N_CH  = 4;
    localparam int OUT_W = 16;
    localparam int GAIN  = 3;
    localparam int CH_W  = 2;
    localparam int SHIFT = 44 - 15 - GAIN;

    localparam logic signed [127:0] CB_OUT = 128'sd1453738;
    localparam logic signed [127:0] CB_MID = 128'sd2907476;
    localparam logic signed [127:0] CA1    = -128'sd35180464440230;
    localparam logic signed [127:0] CA2    = 128'sd17588284210766;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  smp_stb = 1'b0;
    logic [N_CH-1:0]       ds_bits = '0;
    logic                  res_vld;
    logic [CH_W-1:0]       res_ch;
    logic [OUT_W-1:0]      res_word;
    logic [N_CH*OUT_W-1:0] ch_words;

    always #2 clk = ~clk;

    mcbq_filter #(
        .N_CH         (N_CH),
        .OUT_W        (OUT_W),
        .OUT_GAIN_SHL (GAIN)
    ) i_mcbq_filter (
        .clk      (clk),
        .rst      (rst),
        .smp_stb  (smp_stb),
        .ds_bits  (ds_bits),
        .res_vld  (res_vld),
        .res_ch   (res_ch),
        .res_word (res_word),
        .ch_words (ch_words)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    q_ch[$];
    int    q_word[$];
    int    last_word[N_CH];
    string phase = "R7";

    logic signed [127:0] ry1 [N_CH];
    logic signed [127:0] ry2 [N_CH];
    bit                  ron1 [N_CH];
    bit                  rpos1 [N_CH];
    bit                  ron2 [N_CH];
    bit                  rpos2 [N_CH];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    function automatic logic signed [127:0] tap(input bit on, input bit pos,
                                                input logic signed [127:0] k);
        if (!on) return 128'sd0;
        return pos ? k : -k;
    endfunction

    task automatic ref_clear();
        for (int c = 0; c < N_CH; c++) begin
            ry1[c] = 0; ry2[c] = 0;
            ron1[c] = 0; rpos1[c] = 0; ron2[c] = 0; rpos2[c] = 0;
            last_word[c] = 0;
        end
        q_ch.delete();
        q_word.delete();
    endtask

    // Scoreboard driver side: expected words for one sample of every channel
    task automatic push_sample(input logic [N_CH-1:0] b);
        for (int c = 0; c < N_CH; c++) begin
            logic signed [127:0] acc;
            logic signed [127:0] yn;
            logic signed [127:0] q;
            int w;
            acc = ((tap(1'b1, b[c], CB_OUT) + tap(ron1[c], rpos1[c], CB_MID)
                  + tap(ron2[c], rpos2[c], CB_OUT)) <<< 44)
                  - CA1 * ry1[c] - CA2 * ry2[c];
            yn = (acc + (128'sd1 <<< 43)) >>> 44;
            q  = (yn + (128'sd1 <<< (SHIFT - 1))) >>> SHIFT;
            if (q > 128'sd32767) w = 32767;
            else if (q < -128'sd32768) w = -32768;
            else w = int'(q);
            ron2[c] = ron1[c]; rpos2[c] = rpos1[c];
            ron1[c] = 1'b1;    rpos1[c] = b[c];
            ry2[c] = ry1[c];   ry1[c] = yn;
            q_ch.push_back(c);
            q_word.push_back(w);
            last_word[c] = w;
        end
    endtask

    // Scoreboard monitor side
    always @(negedge clk) begin
        if (!rst && res_vld) begin
            if (q_ch.size() == 0) begin
                check(1'b0, "R5 unexpected result", int'(res_ch), -1);
            end else begin
                int ec;
                int ew;
                int aw;
                ec = q_ch.pop_front();
                ew = q_word.pop_front();
                aw = int'($signed(res_word));
                check(int'(res_ch) == ec, "R3 channel order", int'(res_ch), ec);
                if (ew == 32767 || ew == -32768)
                    check(aw == ew, {"R9 saturation ", phase}, aw, ew);
                else
                    check(aw == ew, {"R7 R8 value ", phase}, aw, ew);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    function automatic logic [N_CH-1:0] pattern(input int i, input logic [15:0] lf);
        logic [N_CH-1:0] b;
        b[0] = 1'b1;
        b[1] = 1'b0;
        b[2] = ((i % 145) < 87);
        b[3] = lf[0];
        return b;
    endfunction

    task automatic check_reset_state(input string tag);
        check(res_vld == 1'b0, {tag, " res_vld after reset"}, int'(res_vld), 0);
        check(res_word == '0, {tag, " res_word after reset"}, int'(res_word), 0);
        check(ch_words == '0, {tag, " ch_words after reset"}, (ch_words == '0) ? 0 : 1, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_stb = 1'b0;
        repeat (3) @(negedge clk);
        ref_clear();
        rst = 1'b0;
        @(negedge clk);
    endtask

    // First sample from idle, then every strobe lands in the last slot
    task automatic run_stream(input int n, input string tag);
        logic [15:0] lf;
        lf = 16'hACE1;
        phase = tag;
        @(negedge clk);
        ds_bits = pattern(0, lf);
        smp_stb = 1'b1;
        push_sample(ds_bits);
        @(negedge clk);
        smp_stb = 1'b0;
        for (int i = 1; i < n; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            repeat (N_CH - 1) @(negedge clk);
            ds_bits = pattern(i, lf);
            smp_stb = 1'b1;
            push_sample(ds_bits);
            @(negedge clk);
            smp_stb = 1'b0;
            if (i % 50 == 0)
                check(res_vld == 1'b1, "R4 valid continuous across passes", int'(res_vld), 1);
        end
        repeat (N_CH + 3) @(negedge clk);
        check(q_ch.size() == 0, "R4 all chained results delivered", q_ch.size(), 0);
    endtask

    initial begin
        ref_clear();
        do_reset();
        check_reset_state("R1");

        // R2: single strobe from idle
        phase = "R2";
        @(negedge clk);
        ds_bits = 4'b0110;
        smp_stb = 1'b1;
        push_sample(ds_bits);
        @(negedge clk);
        smp_stb = 1'b0;
        check(res_vld == 1'b0, "R2 no result in cycle after capture", int'(res_vld), 0);
        @(negedge clk);
        check(res_vld == 1'b1 && res_ch == '0, "R2 channel 0 result",
              int'(res_vld) * 10 + int'(res_ch), 10);
        repeat (N_CH + 2) @(negedge clk);

        // R5: strobe in a middle slot is dropped
        phase = "R5";
        @(negedge clk);
        ds_bits = 4'b0011;
        smp_stb = 1'b1;
        push_sample(ds_bits);
        @(negedge clk);
        smp_stb = 1'b0;
        @(negedge clk);
        ds_bits = 4'b1100;
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        repeat (N_CH + 2) @(negedge clk);
        check(res_vld == 1'b0, "R5 no pass after dropped strobe", int'(res_vld), 0);
        check(q_ch.size() == 0, "R5 exactly one pass produced", q_ch.size(), 0);

        // R4 R6 R9 R10: long chained stream, dropped bits must not show up
        run_stream(1400, "R4 R6 R10");
        for (int c = 0; c < N_CH; c++) begin
            int hw;
            hw = int'($signed(ch_words[c*OUT_W +: OUT_W]));
            check(hw == last_word[c], "R11 holding register", hw, last_word[c]);
        end
        check(last_word[0] == 32767, "R9 constant high saturates", last_word[0], 32767);
        check(last_word[1] == -32768, "R9 constant low saturates", last_word[1], -32768);

        // R11: holding register keeps its word while idle
        repeat (5) @(negedge clk);
        check(int'($signed(ch_words[2*OUT_W +: OUT_W])) == last_word[2],
              "R11 hold while idle", int'($signed(ch_words[2*OUT_W +: OUT_W])), last_word[2]);

        // R1 R6: reset from a saturated state, then restart from zero history
        do_reset();
        check_reset_state("R1");
        run_stream(60, "R6 R1 history cleared");

        summary();
        $finish;
    end

endmodule